// File: doc/BRIEF.md
# Alphanumeric Mask Editor

The block rewrites a character field under the direction of a picture string. A complete operand field enters on a byte stream and is held in an internal buffer while its length is counted. The picture string then enters on a second byte stream and is read one code at a time, from left to right. Each code may copy the next field character, skip it, insert a blank, insert quoted text, or print the field length. The edited bytes leave on a third stream. Each stream uses valid/ready flow control, and the two input streams each mark their final byte with a last flag.

A decimal prefix in front of a code repeats that code. When a copy or skip code asks for a field character after the field is used up, nothing is emitted for that request and an underflow flag is raised. Field characters that the picture never reaches are dropped when the job ends. A one-cycle `edit_done` pulse closes each job, and the underflow flag is valid during that pulse.

The controller has six states:
- ST_LOAD takes operand bytes. It moves to ST_FETCH on the operand's last byte.
- ST_FETCH reads a picture byte. A copy, skip or blank code leads to ST_RUN. `F` leads to ST_FC. A quote leads to ST_QUOTE. A digit, or any unknown byte, keeps it in ST_FETCH, unless that byte was the last one, in which case it goes to ST_DONE.
- ST_FC expects `C`. If it gets `C` it goes to ST_RUN; any other byte sends it back to ST_FETCH.
- ST_QUOTE passes picture bytes straight to the output until the closing quote, then returns to ST_FETCH.
- ST_RUN carries out the current code once per repetition. When the last repetition completes, it returns to ST_FETCH, or goes to ST_DONE if that code came from the last picture byte.
- ST_DONE pulses `edit_done` and clears the buffer, the count and the flag, then returns to ST_LOAD.

Top module: `mask_editor`

## Requirements
- R1: After reset, `src_ready` is 1 and `msk_ready`, `out_valid` and `edit_done` are 0.
- R2: `msk_ready` stays 0 until the operand byte carrying `src_last` has been accepted.
- R3: Picture byte 0x53 ('S') copies the next unread operand byte to the output.
- R4: Picture byte 0x49 ('I') consumes one operand byte and emits nothing.
- R5: Picture byte 0x42 ('B') emits 0x20 and does not consume an operand byte.
- R6: Picture bytes between two 0x27 quote bytes are emitted unchanged, in order. The quotes themselves are not emitted.
- R7: The pair 0x46 0x43 ("FC") emits the operand length as four ASCII decimal digits, most significant first and zero-padded. Example: a 12-byte field gives "0012".
- R8: A run of ASCII digits in front of a code repeats that code that many times. No prefix, or a prefix of zero, means the code runs once. A prefix may be at most 255.
- R9: A copy or skip code issued after the field is used up emits nothing and sets `underflow`. The flag is valid while `edit_done` is 1 and is cleared for the next job.
- R10: `edit_done` is high for exactly one cycle after the last picture code finishes. Unread operand bytes are discarded, and the next job starts with `src_ready` at 1.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays at 1 and `out_data` does not change, provided the picture stream keeps its own valid byte steady.
- R12: A picture byte that is not a digit, 'S', 'I', 'B', 'F' or a quote is ignored, and any repeat prefix before it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Operand byte is valid |
| src_ready | output | 1 | Block accepts an operand byte |
| src_data | input | 8 | Operand byte |
| src_last | input | 1 | Final byte of the operand field |
| msk_valid | input | 1 | Picture byte is valid |
| msk_ready | output | 1 | Block accepts a picture byte |
| msk_data | input | 8 | Picture byte |
| msk_last | input | 1 | Final byte of the picture string |
| out_valid | output | 1 | Edited byte is valid |
| out_ready | input | 1 | Downstream accepts the edited byte |
| out_data | output | 8 | Edited byte |
| edit_done | output | 1 | One-cycle pulse that ends a job |
| underflow | output | 1 | The picture requested more operand bytes than the field held |

## Verification
Inside a quoted literal, accepting a picture byte and emitting an output byte happen in the same cycle. The picture handshake therefore depends on the output handshake. Alternate cases apply periodic `out_ready` stalls and valid gaps on both input streams while quoted text is passing. The result is judged by comparing the whole output string with the expected one, so a literal byte that is lost or sent twice shows up as a mismatch. A second coincidence is a repeated copy that runs past the end of the field: emission stops and the flag rises in the same step. The bench checks that exactly the available bytes appear and that `underflow` is 1 during `edit_done`.

// File: rtl/mask_edit_pkg.sv
package mask_edit_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_FETCH,
        ST_FC,
        ST_QUOTE,
        ST_RUN,
        ST_DONE
    } edit_state_t;

    typedef enum logic [1:0] {
        OP_COPY,
        OP_SKIP,
        OP_BLANK,
        OP_LEN
    } edit_op_t;

    localparam logic [7:0] CH_COPY  = 8'h53;
    localparam logic [7:0] CH_SKIP  = 8'h49;
    localparam logic [7:0] CH_BLANK = 8'h42;
    localparam logic [7:0] CH_F     = 8'h46;
    localparam logic [7:0] CH_C     = 8'h43;
    localparam logic [7:0] CH_QUOTE = 8'h27;
    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_ZERO  = 8'h30;

    function automatic logic is_digit(input logic [7:0] b);
        return (b >= 8'h30) && (b <= 8'h39);
    endfunction

endpackage

// File: rtl/mask_src_buf.sv
module mask_src_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_adv,
    output logic [DW-1:0] rd_data,
    output logic          rd_avail
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en && (wr_cnt < CW'(DEPTH))) wr_cnt <= wr_cnt + 1'b1;
            if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && (wr_cnt < CW'(DEPTH))) mem[wr_cnt[AW-1:0]] <= wr_data;
    end

    assign rd_avail = rd_ptr < wr_cnt;
    assign rd_data  = mem[rd_ptr[AW-1:0]];

    // R9
    read_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> rd_avail);

endmodule

// File: rtl/mask_len_bcd.sv
module mask_len_bcd #(
    parameter int DIGITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   inc,
    output logic [DIGITS-1:0][3:0] digits
);
    logic [DIGITS-1:0][3:0] dig_q;
    logic [DIGITS-1:0][3:0] dig_d;
    logic                   all_nine;

    always_comb begin
        logic carry;
        all_nine = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (dig_q[i] != 4'd9) all_nine = 1'b0;
        end
        carry = inc && !all_nine;
        dig_d = dig_q;
        for (int i = 0; i < DIGITS; i++) begin
            if (carry) begin
                if (dig_q[i] == 4'd9) begin
                    dig_d[i] = 4'd0;
                end else begin
                    dig_d[i] = dig_q[i] + 4'd1;
                    carry    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dig_q <= '0;
        else if (clr) dig_q <= '0;
        else          dig_q <= dig_d;
    end

    assign digits = dig_q;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig_chk
        // R7
        bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q[g] <= 4'd9);
    end

endmodule

// File: rtl/mask_editor.sv
module mask_editor
    import mask_edit_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int REP_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_valid,
    output logic       src_ready,
    input  logic [7:0] src_data,
    input  logic       src_last,
    input  logic       msk_valid,
    output logic       msk_ready,
    input  logic [7:0] msk_data,
    input  logic       msk_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       edit_done,
    output logic       underflow
);
    localparam int LEN_DIGITS = 4;

    edit_state_t state_q, state_d;
    edit_op_t    op_q, op_d;
    logic [REP_W-1:0] rep_q, rep_d, acc_q, acc_d, rep_start;
    logic [1:0]  dig_q, dig_d;
    logic        mlast_q, mlast_d, uflow_q, uflow_d;

    logic        src_hs, msk_hs, step_done, rd_adv, rd_avail, clr;
    logic [7:0]  rd_data;
    logic [LEN_DIGITS-1:0][3:0] len_bcd;

    assign src_hs    = src_valid && src_ready;
    assign msk_hs    = msk_valid && msk_ready;
    assign clr       = (state_q == ST_DONE);
    assign rep_start = (acc_q == '0) ? REP_W'(1) : acc_q;

    mask_src_buf #(.DEPTH(DEPTH), .DW(8)) i_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(src_hs), .wr_data(src_data),
        .rd_adv(rd_adv), .rd_data(rd_data), .rd_avail(rd_avail)
    );

    mask_len_bcd #(.DIGITS(LEN_DIGITS)) i_len (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(src_hs), .digits(len_bcd)
    );

    // Output and handshake decode
    always_comb begin
        src_ready = 1'b0;
        msk_ready = 1'b0;
        out_valid = 1'b0;
        out_data  = CH_SPACE;
        rd_adv    = 1'b0;
        step_done = 1'b0;
        unique case (state_q)
            ST_LOAD:  src_ready = 1'b1;
            ST_FETCH: msk_ready = 1'b1;
            ST_FC:    msk_ready = 1'b1;
            ST_QUOTE: begin
                msk_ready = (msk_data == CH_QUOTE) || out_ready;
                out_valid = msk_valid && (msk_data != CH_QUOTE);
                out_data  = msk_data;
            end
            ST_RUN: begin
                unique case (op_q)
                    OP_COPY: begin
                        out_valid = rd_avail;
                        out_data  = rd_data;
                        rd_adv    = rd_avail && out_ready;
                        step_done = rd_avail ? out_ready : 1'b1;
                    end
                    OP_SKIP: begin
                        rd_adv    = rd_avail;
                        step_done = 1'b1;
                    end
                    OP_BLANK: begin
                        out_valid = 1'b1;
                        step_done = out_ready;
                    end
                    OP_LEN: begin
                        out_valid = 1'b1;
                        out_data  = CH_ZERO | {4'd0, len_bcd[2'd3 - dig_q]};
                        step_done = out_ready && (dig_q == 2'd3);
                    end
                endcase
            end
            ST_DONE: ;
        endcase
    end

    assign edit_done = (state_q == ST_DONE);
    assign underflow = uflow_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        rep_d   = rep_q;
        acc_d   = acc_q;
        dig_d   = dig_q;
        mlast_d = mlast_q;
        uflow_d = uflow_q;
        unique case (state_q)
            ST_LOAD: if (src_hs && src_last) state_d = ST_FETCH;
            ST_FETCH: if (msk_hs) begin
                mlast_d = msk_last;
                acc_d   = '0;
                state_d = msk_last ? ST_DONE : ST_FETCH;
                if (is_digit(msk_data)) begin
                    acc_d = acc_q * REP_W'(10) + REP_W'(msk_data[3:0]);
                end else if (msk_data == CH_COPY || msk_data == CH_SKIP ||
                             msk_data == CH_BLANK) begin
                    op_d    = (msk_data == CH_COPY) ? OP_COPY :
                              (msk_data == CH_SKIP) ? OP_SKIP : OP_BLANK;
                    rep_d   = rep_start;
                    state_d = ST_RUN;
                end else if (msk_data == CH_F && !msk_last) begin
                    acc_d   = acc_q;
                    state_d = ST_FC;
                end else if (msk_data == CH_QUOTE && !msk_last) begin
                    state_d = ST_QUOTE;
                end
            end
            ST_FC: if (msk_hs) begin
                mlast_d = msk_last;
                acc_d   = '0;
                dig_d   = '0;
                if (msk_data == CH_C) begin
                    op_d    = OP_LEN;
                    rep_d   = rep_start;
                    state_d = ST_RUN;
                end else begin
                    state_d = msk_last ? ST_DONE : ST_FETCH;
                end
            end
            ST_QUOTE: if (msk_hs && (msk_last || msk_data == CH_QUOTE)) begin
                state_d = msk_last ? ST_DONE : ST_FETCH;
            end
            ST_RUN: begin
                if ((op_q == OP_COPY || op_q == OP_SKIP) && !rd_avail) uflow_d = 1'b1;
                if (op_q == OP_LEN && out_ready) dig_d = dig_q + 2'd1;
                if (step_done) begin
                    if (rep_q == REP_W'(1)) state_d = mlast_q ? ST_DONE : ST_FETCH;
                    else                    rep_d   = rep_q - 1'b1;
                end
            end
            ST_DONE: begin
                uflow_d = 1'b0;
                acc_d   = '0;
                state_d = ST_LOAD;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            op_q    <= OP_COPY;
            rep_q   <= '0;
            acc_q   <= '0;
            dig_q   <= '0;
            mlast_q <= 1'b0;
            uflow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            rep_q   <= rep_d;
            acc_q   <= acc_d;
            dig_q   <= dig_d;
            mlast_q <= mlast_d;
            uflow_q <= uflow_d;
        end
    end

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && !src_last) |=> !msk_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edit_done |=> !edit_done);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && (state_q == ST_RUN)) |=> (out_valid && $stable(out_data)));

    // R9
    underflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> ($past(state_q) == ST_RUN));

endmodule

// File: tb/test_mask_editor.sv
`timescale 1ns/1ps
module test_mask_editor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_valid = 1'b0, src_last = 1'b0;
    logic [7:0] src_data = '0;
    logic       msk_valid = 1'b0, msk_last = 1'b0;
    logic [7:0] msk_data = '0;
    logic       out_ready = 1'b0;
    logic       src_ready, msk_ready, out_valid, edit_done, underflow;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mask_editor i_mask_editor (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
        .msk_valid(msk_valid), .msk_ready(msk_ready), .msk_data(msk_data), .msk_last(msk_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .edit_done(edit_done), .underflow(underflow)
    );

    localparam int NV = 12;
    localparam bit [191:0] OPS [NV] = '{
        "6N491-XMT", "6N491-XMT", "6N491-XMT", "6N491-XMT", "ABC", "HELLO",
        "XY", "ABCDEFGHIJKL", "Q", "WXYZ", "ABCDEF", "Z"};
    localparam bit [191:0] MSKS [NV] = '{
        "IISSS", "SBSBSSSISSS", "FC", "5S' KIT'", "2I3S", "S3BS",
        "S?S", "2FC", "'AB'S", "0SS", "12S", "S"};
    localparam bit [191:0] EXPS [NV] = '{
        "491", "6 N 491XMT", "0009", "6N491 KIT", "C", "H   E",
        "XY", "00120012", "ABQ", "WX", "ABCDEF", "Z"};
    localparam bit EXP_UF [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0};
    localparam bit [23:0] TAGS [NV] = '{
        "R4 ", "R5 ", "R7 ", "R6 ", "R9 ", "R8 ",
        "R12", "R7 ", "R6 ", "R10", "R8 ", "R3 "};

    function automatic string unpad(input bit [191:0] v);
        string s = "";
        for (int i = 23; i >= 0; i--) begin
            if (v[i*8 +: 8] != 8'h00) s = $sformatf("%s%c", s, v[i*8 +: 8]);
        end
        return s;
    endfunction

    task automatic run_case(input int k);
        string op, mk, exp, got;
        int oi, mi, guard;
        bit done, uf, bp, s_hold, m_hold, o_hold;
        logic [7:0] o_prev;
        op = unpad(OPS[k]); mk = unpad(MSKS[k]); exp = unpad(EXPS[k]);
        got = ""; oi = 0; mi = 0; guard = 0; done = 0; uf = 0;
        bp = (k % 2) == 1; s_hold = 0; m_hold = 0; o_hold = 0; o_prev = '0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
            src_valid = (oi < op.len()) && (s_hold || !(bp && (cyc % 4 == 2)));
            src_data  = op[oi];
            src_last  = (oi == op.len() - 1);
            msk_valid = (mi < mk.len()) && (m_hold || !(bp && (cyc % 4 == 0)));
            msk_data  = mk[mi];
            msk_last  = (mi == mk.len() - 1);
            out_ready = !(bp && (cyc % 3 == 1));
            #1;
            if (o_hold) begin
                checks++;
                if (!out_valid || out_data !== o_prev) begin
                    errors++;
                    $display("FAIL R11 case %0d out_valid %b out_data %h expected 1 %h",
                             k, out_valid, out_data, o_prev);
                end
            end
            if (oi < op.len()) begin
                checks++;
                if (msk_ready) begin
                    errors++;
                    $display("FAIL R2 case %0d msk_ready %b expected 0", k, msk_ready);
                end
            end
            s_hold = src_valid && !src_ready;
            m_hold = msk_valid && !msk_ready;
            o_hold = out_valid && !out_ready;
            o_prev = out_data;
            if (src_valid && src_ready) oi++;
            if (msk_valid && msk_ready) mi++;
            if (out_valid && out_ready) got = $sformatf("%s%c", got, out_data);
            if (edit_done) begin
                done = 1;
                uf = underflow;
            end
        end
        checks++;
        if (!done || got != exp) begin
            errors++;
            $display("FAIL %s case %0d output \"%s\" expected \"%s\"", TAGS[k], k, got, exp);
        end
        checks++;
        if (uf != EXP_UF[k]) begin
            errors++;
            $display("FAIL R9 case %0d underflow %b expected %b", k, uf, EXP_UF[k]);
        end
        @(negedge clk);
        src_valid = 1'b0; msk_valid = 1'b0;
        #1;
        checks++;
        if (edit_done !== 1'b0 || src_ready !== 1'b1 || underflow !== 1'b0) begin
            errors++;
            $display("FAIL R10 case %0d done %b src_ready %b underflow %b expected 0 1 0",
                     k, edit_done, src_ready, underflow);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        checks++;
        if (src_ready !== 1'b1 || msk_ready !== 1'b0 || out_valid !== 1'b0 || edit_done !== 1'b0) begin
            errors++;
            $display("FAIL R1 src_ready %b msk_ready %b out_valid %b done %b expected 1 0 0 0",
                     src_ready, msk_ready, out_valid, edit_done);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) run_case(k);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule